// File: doc/BRIEF.md
# Device Error Classifier and Message Signaler

This block sits beside a device function and turns single error events into status bits and outgoing error messages. Each event names one error bit and says whether it belongs to the correctable or the uncorrectable class. A non-fatal uncorrectable event may also be flagged as possibly advisory. The block validates the event and keeps the correctable, uncorrectable and device status registers. It applies the correctable and uncorrectable mask registers and takes the severity of uncorrectable errors from a programmable severity register. It then checks the command and device control enables to decide whether a correctable, non-fatal or fatal message leaves the block, tagged with the event's 16-bit source ID.

Header capture lives in a separate logger. The block raises a log request with the one-hot error bit in the same cycle as the event, and the logger answers on `log_full_i` in that cycle. When the logger is full and the event also produced a message, the block injects a correctable header-log-overflow event on its own in the following cycle. Software clears status bits by writing ones through a small register write port with byte enables. The same port writes the masks and the severity register.

Bit map. Uncorrectable bits 0..15 are supported:
- bit 0 internal, 1 link protocol, 2 surprise down, 3 receiver overflow, 4 flow-control protocol, 5 malformed packet;
- bit 6 poisoned, 7 end-to-end CRC, 8 unsupported request, 9 completion timeout, 10 completer abort, 11 unexpected completion, 12 access-control violation, 13 multicast blocked, 14 atomic egress blocked, 15 prefix blocked.

Correctable bits 0..7 are supported. The block acts on bit 5, advisory non-fatal, and bit 7, header-log overflow. Device status bits are: 0 correctable seen, 1 non-fatal seen, 2 fatal seen, 3 unsupported request seen. Register addresses are:

| Address | Register |
|---|---|
| 0 | correctable status |
| 1 | correctable mask |
| 2 | uncorrectable status |
| 3 | uncorrectable mask |
| 4 | severity |
| 5 | device status |

Message severity codes are 0 correctable, 1 non-fatal and 2 fatal.

Top module: `dev_err_signal`

## Requirements
- R1: An event whose status, masked to the supported bits of its class, is zero or has more than one bit set is rejected: no status, log request or message results.
- R2: A correctable event sets its bit in correctable status and device status bit 0; with the correctable enable set it emits a severity-0 message.
- R3: A correctable event whose bit is set in the correctable mask still sets its status bits, but emits no message.
- R4: An uncorrectable event is fatal when its bit in the severity register is 1 (reset value 0x3F) and non-fatal otherwise; it sets device status bit 2 or bit 1 accordingly, and sets its uncorrectable status bit.
- R5: With HAS_SEV_REG = 0, severity writes are ignored and bits 0..5 are fatal, all others non-fatal.
- R6: An uncorrectable event masked in the uncorrectable mask sets its status bit but raises no log request and no message.
- R7: A non-fatal uncorrectable event flagged possibly-advisory is handled as correctable bit 5. If bit 5 is not masked, the original uncorrectable status bit is set, and a log request is raised only when that bit is unmasked in the uncorrectable mask. If bit 5 is masked, the uncorrectable status is left untouched.
- R8: An unsupported request (uncorrectable bit 8) sets device status bit 3. With the unsupported-request enable clear it emits no message, except in the uncorrectable path when the command SERR enable is set.
- R9: A fatal message needs SERR enable or the fatal enable, a non-fatal message needs SERR enable or the non-fatal enable, and a correctable message needs the correctable enable.
- R10: When a log request meets `log_full_i` and a message is emitted, the next cycle processes a correctable bit-7 event with the same source ID.
- R11: Writes to status registers clear the written-one bits within the enabled bytes. Writes to masks and severity replace the enabled bytes. A status bit set by an event in the same cycle as its clear stays set.
- R12: A message appears as a one-cycle `msg_valid_o` pulse in the cycle after the event. The log request is combinational in the event cycle.
- R13: An external event presented in the cycle that processes an injected overflow event is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid_i | input | 1 | Error event present this cycle |
| evt_status_i | input | 32 | Error bit of the event |
| evt_is_cor_i | input | 1 | Event is of the correctable class |
| evt_maybe_adv_i | input | 1 | Non-fatal uncorrectable event may be advisory |
| evt_src_i | input | 16 | Source ID of the event |
| cmd_serr_en_i | input | 1 | Command SERR enable |
| ctl_cor_en_i | input | 1 | Correctable reporting enable |
| ctl_nf_en_i | input | 1 | Non-fatal reporting enable |
| ctl_fatal_en_i | input | 1 | Fatal reporting enable |
| ctl_ur_en_i | input | 1 | Unsupported-request reporting enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_be_i | input | 4 | Byte enables |
| log_full_i | input | 1 | Logger cannot take the request |
| log_req_o | output | 1 | Header log request |
| log_bit_o | output | 32 | One-hot uncorrectable bit to log |
| log_src_o | output | 16 | Source ID for the log request |
| msg_valid_o | output | 1 | Message pulse |
| msg_sev_o | output | 2 | Message severity code |
| msg_src_o | output | 16 | Message source ID |
| cor_sts_o | output | 32 | Correctable status |
| unc_sts_o | output | 32 | Uncorrectable status |
| dev_sts_o | output | 4 | Device status flags |

## Verification
On every cycle the assertions check four things. A rejected event leaves every status register unchanged and sends nothing. Each message severity was allowed by the enables of the event's cycle. A log request carries a single bit that is unmasked. An overflow injection follows a message and blocks outside events. Some rules need a sequence of events and can only be shown by the bench scenarios against its reference model. These are advisory conversion under both mask settings, the unsupported-request exceptions and severity reprogramming. They also cover clearing by byte, where an event in the same cycle wins, and the fixed severity table of the variant without a severity register.

// File: rtl/dev_err_pkg.sv
package dev_err_pkg;

    typedef enum logic [1:0] {
        SEV_COR      = 2'd0,
        SEV_NONFATAL = 2'd1,
        SEV_FATAL    = 2'd2
    } err_sev_e;

    localparam int DEV_W    = 4;
    localparam int DS_COR   = 0;
    localparam int DS_NF    = 1;
    localparam int DS_FATAL = 2;
    localparam int DS_UR    = 3;

    localparam logic [2:0] ADDR_COR_STS = 3'd0;
    localparam logic [2:0] ADDR_COR_MSK = 3'd1;
    localparam logic [2:0] ADDR_UNC_STS = 3'd2;
    localparam logic [2:0] ADDR_UNC_MSK = 3'd3;
    localparam logic [2:0] ADDR_UNC_SEV = 3'd4;
    localparam logic [2:0] ADDR_DEV_STS = 3'd5;

endpackage

// File: rtl/dev_err_classify.sv
module dev_err_classify #(
    parameter int              REG_W   = 32,
    parameter logic [REG_W-1:0] UNC_SUP = 32'h0000_FFFF,
    parameter logic [REG_W-1:0] COR_SUP = 32'h0000_00FF,
    parameter int              UR_BIT  = 8
) (
    input  logic [REG_W-1:0] status,
    input  logic             is_cor,
    input  logic [REG_W-1:0] sev_map,
    output logic             ok,
    output logic [REG_W-1:0] kept,
    output logic             is_ur,
    output logic             is_fatal
);
    localparam logic [REG_W-1:0] UR_VEC = REG_W'(1) << UR_BIT;

    always_comb begin
        kept     = status & (is_cor ? COR_SUP : UNC_SUP);
        ok       = (kept != '0) && ((kept & (kept - REG_W'(1))) == '0);
        is_ur    = !is_cor && (status == UR_VEC);
        is_fatal = !is_cor && ((kept & sev_map) != '0);
    end
endmodule

// File: rtl/dev_err_route.sv
module dev_err_route
    import dev_err_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int ADV_BIT = 5
) (
    input  logic             ev_ok,
    input  logic             is_cor,
    input  logic             is_ur,
    input  logic             is_fatal,
    input  logic             maybe_adv,
    input  logic [REG_W-1:0] ev_bit,
    input  logic [REG_W-1:0] cor_msk,
    input  logic [REG_W-1:0] unc_msk,
    input  logic             serr_en,
    input  logic             cor_en,
    input  logic             nf_en,
    input  logic             fatal_en,
    input  logic             ur_en,
    input  logic             log_full,
    output logic [REG_W-1:0] cor_set,
    output logic [REG_W-1:0] unc_set,
    output logic [DEV_W-1:0] dev_set,
    output logic             log_req,
    output logic [REG_W-1:0] log_bit,
    output logic             send,
    output err_sev_e         sev,
    output logic             ovf
);
    localparam logic [REG_W-1:0] ADV_VEC = REG_W'(1) << ADV_BIT;

    logic             adv_path;
    logic [REG_W-1:0] cbit;

    always_comb begin
        cor_set  = '0;
        unc_set  = '0;
        dev_set  = '0;
        log_req  = 1'b0;
        log_bit  = '0;
        send     = 1'b0;
        sev      = SEV_COR;
        adv_path = !is_cor;
        cbit     = is_cor ? ev_bit : ADV_VEC;
        if (ev_ok) begin
            if (is_cor || (!is_fatal && maybe_adv)) begin
                dev_set[DS_COR] = 1'b1;
                dev_set[DS_UR]  = is_ur;
                cor_set         = cbit;
                if ((cor_msk & cbit) == '0) begin
                    if (adv_path) begin
                        unc_set = ev_bit;
                        if ((unc_msk & ev_bit) == '0) begin
                            log_req = 1'b1;
                            log_bit = ev_bit;
                        end
                    end
                    if (!(is_ur && !ur_en) && cor_en) begin
                        send = 1'b1;
                        sev  = SEV_COR;
                    end
                end
            end else begin
                dev_set[is_fatal ? DS_FATAL : DS_NF] = 1'b1;
                dev_set[DS_UR] = is_ur;
                unc_set        = ev_bit;
                if ((unc_msk & ev_bit) == '0) begin
                    log_req = 1'b1;
                    log_bit = ev_bit;
                    if (!(is_ur && !ur_en && !serr_en)) begin
                        if (is_fatal) begin
                            if (serr_en || fatal_en) begin
                                send = 1'b1;
                                sev  = SEV_FATAL;
                            end
                        end else if (serr_en || nf_en) begin
                            send = 1'b1;
                            sev  = SEV_NONFATAL;
                        end
                    end
                end
            end
        end
        ovf = send && log_req && log_full;
    end

    always_comb begin
        if (send) begin
            a_r9_send_enabled: assert (sev == SEV_COR ? cor_en :
                (serr_en || (sev == SEV_FATAL ? fatal_en : nf_en)))
                else $error("message without enable");
        end
        if (log_req) begin
            a_r6_log_unmasked: assert ($onehot(log_bit) && ((unc_msk & log_bit) == '0))
                else $error("bad log request");
        end
    end
endmodule

// File: rtl/dev_err_signal.sv
module dev_err_signal
    import dev_err_pkg::*;
#(
    parameter int               REG_W         = 32,
    parameter int               SRC_W         = 16,
    parameter logic [REG_W-1:0] UNC_SUP       = 32'h0000_FFFF,
    parameter logic [REG_W-1:0] COR_SUP       = 32'h0000_00FF,
    parameter logic [REG_W-1:0] FATAL_DEFAULT = 32'h0000_003F,
    parameter int               UR_BIT        = 8,
    parameter int               ADV_BIT       = 5,
    parameter int               HLO_BIT       = 7,
    parameter bit               HAS_SEV_REG   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid_i,
    input  logic [REG_W-1:0]   evt_status_i,
    input  logic               evt_is_cor_i,
    input  logic               evt_maybe_adv_i,
    input  logic [SRC_W-1:0]   evt_src_i,
    input  logic               cmd_serr_en_i,
    input  logic               ctl_cor_en_i,
    input  logic               ctl_nf_en_i,
    input  logic               ctl_fatal_en_i,
    input  logic               ctl_ur_en_i,
    input  logic               reg_wr_i,
    input  logic [2:0]         reg_addr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    input  logic [REG_W/8-1:0] reg_be_i,
    input  logic               log_full_i,
    output logic               log_req_o,
    output logic [REG_W-1:0]   log_bit_o,
    output logic [SRC_W-1:0]   log_src_o,
    output logic               msg_valid_o,
    output logic [1:0]         msg_sev_o,
    output logic [SRC_W-1:0]   msg_src_o,
    output logic [REG_W-1:0]   cor_sts_o,
    output logic [REG_W-1:0]   unc_sts_o,
    output logic [DEV_W-1:0]   dev_sts_o
);
    localparam int               BE_W    = REG_W / 8;
    localparam logic [REG_W-1:0] HLO_VEC = REG_W'(1) << HLO_BIT;

    typedef struct packed {
        logic [REG_W-1:0] cor_sts;
        logic [REG_W-1:0] cor_msk;
        logic [REG_W-1:0] unc_sts;
        logic [REG_W-1:0] unc_msk;
        logic [REG_W-1:0] sev;
        logic [DEV_W-1:0] dev_sts;
        logic             msg_valid;
        err_sev_e         msg_sev;
        logic [SRC_W-1:0] msg_src;
        logic             ovf_pend;
        logic [SRC_W-1:0] ovf_src;
    } sig_state_t;

    sig_state_t state_d, state_q;

    function automatic logic [REG_W-1:0] be_expand(input logic [BE_W-1:0] be);
        logic [REG_W-1:0] m;
        for (int i = 0; i < BE_W; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    // event source: the pending overflow injection takes the slot
    logic             ev_active;
    logic [REG_W-1:0] ev_status;
    logic             ev_is_cor;
    logic             ev_adv;
    logic [SRC_W-1:0] ev_src;
    logic [REG_W-1:0] sev_map;
    logic [REG_W-1:0] wmask;

    always_comb begin
        ev_active = state_q.ovf_pend | evt_valid_i;
        ev_status = state_q.ovf_pend ? HLO_VEC : evt_status_i;
        ev_is_cor = state_q.ovf_pend | evt_is_cor_i;
        ev_adv    = !state_q.ovf_pend & evt_maybe_adv_i;
        ev_src    = state_q.ovf_pend ? state_q.ovf_src : evt_src_i;
        wmask     = be_expand(reg_be_i);
    end

    generate
        if (HAS_SEV_REG) begin : g_sev_prog
            assign sev_map = state_q.sev;
        end else begin : g_sev_fixed
            assign sev_map = FATAL_DEFAULT;
        end
    endgenerate

    logic             cls_ok;
    logic [REG_W-1:0] cls_bit;
    logic             cls_ur;
    logic             cls_fatal;

    dev_err_classify #(
        .REG_W  (REG_W),
        .UNC_SUP(UNC_SUP),
        .COR_SUP(COR_SUP),
        .UR_BIT (UR_BIT)
    ) u_classify (
        .status  (ev_status),
        .is_cor  (ev_is_cor),
        .sev_map (sev_map),
        .ok      (cls_ok),
        .kept    (cls_bit),
        .is_ur   (cls_ur),
        .is_fatal(cls_fatal)
    );

    logic [REG_W-1:0] rt_cor_set, rt_unc_set, rt_log_bit;
    logic [DEV_W-1:0] rt_dev_set;
    logic             rt_log_req, rt_send, rt_ovf;
    err_sev_e         rt_sev;

    dev_err_route #(
        .REG_W  (REG_W),
        .ADV_BIT(ADV_BIT)
    ) u_route (
        .ev_ok    (ev_active && cls_ok),
        .is_cor   (ev_is_cor),
        .is_ur    (cls_ur),
        .is_fatal (cls_fatal),
        .maybe_adv(ev_adv),
        .ev_bit   (cls_bit),
        .cor_msk  (state_q.cor_msk),
        .unc_msk  (state_q.unc_msk),
        .serr_en  (cmd_serr_en_i),
        .cor_en   (ctl_cor_en_i),
        .nf_en    (ctl_nf_en_i),
        .fatal_en (ctl_fatal_en_i),
        .ur_en    (ctl_ur_en_i),
        .log_full (log_full_i),
        .cor_set  (rt_cor_set),
        .unc_set  (rt_unc_set),
        .dev_set  (rt_dev_set),
        .log_req  (rt_log_req),
        .log_bit  (rt_log_bit),
        .send     (rt_send),
        .sev      (rt_sev),
        .ovf      (rt_ovf)
    );

    always_comb begin
        state_d           = state_q;
        state_d.msg_valid = 1'b0;
        state_d.ovf_pend  = 1'b0;
        if (reg_wr_i) begin
            case (reg_addr_i)
                ADDR_COR_STS: state_d.cor_sts = state_q.cor_sts & ~(reg_wdata_i & wmask);
                ADDR_COR_MSK: state_d.cor_msk = (state_q.cor_msk & ~wmask) |
                                                (reg_wdata_i & wmask & COR_SUP);
                ADDR_UNC_STS: state_d.unc_sts = state_q.unc_sts & ~(reg_wdata_i & wmask);
                ADDR_UNC_MSK: state_d.unc_msk = (state_q.unc_msk & ~wmask) |
                                                (reg_wdata_i & wmask & UNC_SUP);
                ADDR_UNC_SEV: begin
                    if (HAS_SEV_REG) begin
                        state_d.sev = (state_q.sev & ~wmask) | (reg_wdata_i & wmask & UNC_SUP);
                    end
                end
                ADDR_DEV_STS: state_d.dev_sts = state_q.dev_sts &
                                                ~(reg_wdata_i[DEV_W-1:0] & wmask[DEV_W-1:0]);
                default: ;
            endcase
        end
        // event sets land after the write clears: a same-cycle set wins
        state_d.cor_sts = state_d.cor_sts | rt_cor_set;
        state_d.unc_sts = state_d.unc_sts | rt_unc_set;
        state_d.dev_sts = state_d.dev_sts | rt_dev_set;
        if (rt_send) begin
            state_d.msg_valid = 1'b1;
            state_d.msg_sev   = rt_sev;
            state_d.msg_src   = ev_src;
        end
        if (rt_ovf) begin
            state_d.ovf_pend = 1'b1;
            state_d.ovf_src  = ev_src;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q         <= '0;
            state_q.sev     <= FATAL_DEFAULT & UNC_SUP;
            state_q.msg_sev <= SEV_COR;
        end else begin
            state_q <= state_d;
        end
    end

    assign log_req_o   = rt_log_req;
    assign log_bit_o   = rt_log_bit;
    assign log_src_o   = ev_src;
    assign msg_valid_o = state_q.msg_valid;
    assign msg_sev_o   = state_q.msg_sev;
    assign msg_src_o   = state_q.msg_src;
    assign cor_sts_o   = state_q.cor_sts;
    assign unc_sts_o   = state_q.unc_sts;
    assign dev_sts_o   = state_q.dev_sts;

    a_r1_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && !state_q.ovf_pend && !cls_ok && !reg_wr_i) |=>
        (!state_q.msg_valid && $stable(state_q.cor_sts) &&
         $stable(state_q.unc_sts) && $stable(state_q.dev_sts)))
        else $error("rejected event changed state");

    a_r9_fatal_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.msg_valid && state_q.msg_sev == SEV_FATAL) |->
        $past(cmd_serr_en_i || ctl_fatal_en_i))
        else $error("fatal message without enable");

    a_r9_cor_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.msg_valid && state_q.msg_sev == SEV_COR) |-> $past(ctl_cor_en_i))
        else $error("correctable message without enable");

    a_r10_ovf_after_msg: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ovf_pend |-> state_q.msg_valid)
        else $error("overflow injection without message");

    a_r13_ovf_slot: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ovf_pend |=> (!state_q.msg_valid || state_q.msg_sev == SEV_COR))
        else $error("external event took the overflow slot");
endmodule

// File: tb/dev_err_signal_tb.sv
module dev_err_signal_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [31:0] evt_status = '0;
    logic        evt_is_cor = 1'b0;
    logic        evt_adv = 1'b0;
    logic [15:0] evt_src = '0;
    logic        serr_en = 1'b0;
    logic        cor_en = 1'b1;
    logic        nf_en = 1'b1;
    logic        fatal_en = 1'b1;
    logic        ur_en = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_be = '0;
    logic        log_full = 1'b0;

    logic        log_req, msg_valid;
    logic [31:0] log_bit, cor_sts, unc_sts;
    logic [15:0] log_src, msg_src;
    logic [1:0]  msg_sev;
    logic [3:0]  dev_sts;

    logic        f_log_req, f_msg_valid;
    logic [31:0] f_log_bit, f_cor_sts, f_unc_sts;
    logic [15:0] f_log_src, f_msg_src;
    logic [1:0]  f_msg_sev;
    logic [3:0]  f_dev_sts;

    always #(CLK_PERIOD/2) clk = ~clk;

    dev_err_signal u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid_i(evt_valid), .evt_status_i(evt_status),
        .evt_is_cor_i(evt_is_cor), .evt_maybe_adv_i(evt_adv), .evt_src_i(evt_src),
        .cmd_serr_en_i(serr_en), .ctl_cor_en_i(cor_en), .ctl_nf_en_i(nf_en),
        .ctl_fatal_en_i(fatal_en), .ctl_ur_en_i(ur_en), .reg_wr_i(reg_wr),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_be_i(reg_be),
        .log_full_i(log_full), .log_req_o(log_req), .log_bit_o(log_bit),
        .log_src_o(log_src), .msg_valid_o(msg_valid), .msg_sev_o(msg_sev),
        .msg_src_o(msg_src), .cor_sts_o(cor_sts), .unc_sts_o(unc_sts), .dev_sts_o(dev_sts)
    );

    dev_err_signal #(.HAS_SEV_REG(1'b0)) u_dut_fix (
        .clk(clk), .rst_n(rst_n), .evt_valid_i(evt_valid), .evt_status_i(evt_status),
        .evt_is_cor_i(evt_is_cor), .evt_maybe_adv_i(evt_adv), .evt_src_i(evt_src),
        .cmd_serr_en_i(serr_en), .ctl_cor_en_i(cor_en), .ctl_nf_en_i(nf_en),
        .ctl_fatal_en_i(fatal_en), .ctl_ur_en_i(ur_en), .reg_wr_i(reg_wr),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_be_i(reg_be),
        .log_full_i(log_full), .log_req_o(f_log_req), .log_bit_o(f_log_bit),
        .log_src_o(f_log_src), .msg_valid_o(f_msg_valid), .msg_sev_o(f_msg_sev),
        .msg_src_o(f_msg_src), .cor_sts_o(f_cor_sts), .unc_sts_o(f_unc_sts), .dev_sts_o(f_dev_sts)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "reset";

    // reference model state
    logic [31:0] m_cor = '0, m_cmsk = '0, m_unc = '0, m_umsk = '0, m_sev = 32'h3F;
    logic [3:0]  m_dev = '0;
    bit          m_mv = 1'b0;
    logic [1:0]  m_ms = '0;
    logic [15:0] m_msrc = '0;
    bit          m_pend = 1'b0;
    logic [15:0] m_psrc = '0;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic check_state();
        chk(msg_valid == m_mv, "msg_valid", 32'(msg_valid), 32'(m_mv));
        if (m_mv) begin
            chk(msg_sev == m_ms, "msg_sev", 32'(msg_sev), 32'(m_ms));
            chk(msg_src == m_msrc, "msg_src", 32'(msg_src), 32'(m_msrc));
        end
        chk(cor_sts == m_cor, "cor_sts", cor_sts, m_cor);
        chk(unc_sts == m_unc, "unc_sts", unc_sts, m_unc);
        chk(dev_sts == m_dev, "dev_sts", 32'(dev_sts), 32'(m_dev));
    endtask

    // one clock: model the cycle's inputs, check log outputs, advance, check state
    task automatic cyc();
        logic [31:0] s, k, cb, wm, nc, ncm, nu, num, nsv, lbit;
        logic [3:0]  nd;
        logic [15:0] src;
        logic [1:0]  sv;
        bit act, cor, adv, ur, fat, lreq, send;
        #1;
        nc = m_cor; ncm = m_cmsk; nu = m_unc; num = m_umsk; nsv = m_sev; nd = m_dev;
        for (int i = 0; i < 4; i++) wm[i*8 +: 8] = {8{reg_be[i]}};
        if (reg_wr) begin
            case (reg_addr)
                3'd0: nc  = nc & ~(reg_wdata & wm);
                3'd1: ncm = (ncm & ~wm) | (reg_wdata & wm & 32'hFF);
                3'd2: nu  = nu & ~(reg_wdata & wm);
                3'd3: num = (num & ~wm) | (reg_wdata & wm & 32'hFFFF);
                3'd4: nsv = (nsv & ~wm) | (reg_wdata & wm & 32'hFFFF);
                3'd5: nd  = nd & ~(reg_wdata[3:0] & wm[3:0]);
                default: ;
            endcase
        end
        act = m_pend || evt_valid;
        s   = m_pend ? 32'h80 : evt_status;
        cor = m_pend || evt_is_cor;
        adv = !m_pend && evt_adv;
        src = m_pend ? m_psrc : evt_src;
        lreq = 0; lbit = '0; send = 0; sv = 0;
        k = s & (cor ? 32'hFF : 32'hFFFF);
        if (act && $countones(k) == 1) begin
            ur  = !cor && (s == 32'h100);
            fat = !cor && ((k & m_sev) != 0);
            if (cor || (!fat && adv)) begin
                cb = cor ? k : 32'h20;
                nd[0] = 1'b1;
                if (ur) nd[3] = 1'b1;
                nc = nc | cb;
                if ((m_cmsk & cb) == 0) begin
                    if (!cor) begin
                        nu = nu | k;
                        if ((m_umsk & k) == 0) begin lreq = 1; lbit = k; end
                    end
                    if (!(ur && !ur_en) && cor_en) begin send = 1; sv = 2'd0; end
                end
            end else begin
                if (fat) nd[2] = 1'b1; else nd[1] = 1'b1;
                if (ur) nd[3] = 1'b1;
                nu = nu | k;
                if ((m_umsk & k) == 0) begin
                    lreq = 1; lbit = k;
                    if (!(ur && !ur_en && !serr_en)) begin
                        if (fat && (serr_en || fatal_en)) begin send = 1; sv = 2'd2; end
                        if (!fat && (serr_en || nf_en)) begin send = 1; sv = 2'd1; end
                    end
                end
            end
        end
        chk(log_req == lreq, "log_req", 32'(log_req), 32'(lreq));
        if (lreq) begin
            chk(log_bit == lbit, "log_bit", log_bit, lbit);
            chk(log_src == src, "log_src", 32'(log_src), 32'(src));
        end
        @(posedge clk);
        m_cor = nc; m_cmsk = ncm; m_unc = nu; m_umsk = num; m_sev = nsv; m_dev = nd;
        m_mv = send; m_ms = sv; m_msrc = src;
        m_pend = send && lreq && log_full;
        m_psrc = src;
        @(negedge clk);
        check_state();
        evt_valid = 1'b0;
        evt_adv = 1'b0;
        reg_wr = 1'b0;
    endtask

    task automatic ev(input logic [31:0] st, input bit c, input bit a, input logic [15:0] src);
        evt_valid = 1'b1; evt_status = st; evt_is_cor = c; evt_adv = a; evt_src = src;
        cyc();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        cyc();
    endtask

    bit done = 1'b0;

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "reset";
        check_state();

        cur_req = "R2";
        ev(32'h1, 1, 0, 16'hA001);
        cur_req = "R12";
        cyc();

        cur_req = "R1";
        ev(32'h3, 1, 0, 16'h0001);
        ev(32'h0010_0000, 0, 0, 16'h0002);
        ev(32'h400, 1, 0, 16'h0003);
        ev(32'h0, 0, 0, 16'h0004);

        cur_req = "R3";
        wr(3'd1, 32'h2, 4'hF);
        ev(32'h2, 1, 0, 16'h0005);

        cur_req = "R4";
        ev(32'h1, 0, 0, 16'hC001);
        ev(32'h40, 0, 0, 16'hC002);
        wr(3'd4, 32'h7F, 4'hF);
        ev(32'h40, 0, 0, 16'hC003);

        cur_req = "R6";
        wr(3'd3, 32'h200, 4'hF);
        ev(32'h200, 0, 0, 16'hC004);

        cur_req = "R7";
        ev(32'h400, 0, 1, 16'hD001);
        wr(3'd3, 32'h600, 4'hF);
        ev(32'h400, 0, 1, 16'hD002);
        wr(3'd1, 32'h22, 4'hF);
        ev(32'h800, 0, 1, 16'hD003);
        wr(3'd1, 32'h2, 4'hF);

        cur_req = "R8";
        ur_en = 1'b0;
        ev(32'h100, 0, 0, 16'hE001);
        serr_en = 1'b1;
        ev(32'h100, 0, 0, 16'hE002);
        serr_en = 1'b0;
        ev(32'h100, 0, 1, 16'hE003);
        ur_en = 1'b1;

        cur_req = "R9";
        fatal_en = 1'b0;
        ev(32'h1, 0, 0, 16'hF001);
        serr_en = 1'b1;
        ev(32'h1, 0, 0, 16'hF002);
        serr_en = 1'b0; nf_en = 1'b0;
        ev(32'h80, 0, 0, 16'hF003);
        cor_en = 1'b0;
        ev(32'h1, 1, 0, 16'hF004);
        cor_en = 1'b1; nf_en = 1'b1; fatal_en = 1'b1;

        cur_req = "R10";
        log_full = 1'b1;
        ev(32'h1, 0, 0, 16'hB00B);
        cur_req = "R13";
        ev(32'h4000, 0, 0, 16'h1234);
        cur_req = "R10";
        cyc();
        log_full = 1'b0;

        cur_req = "R11";
        wr(3'd0, 32'hFFFF_FF01, 4'h1);
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h1; reg_be = 4'hF;
        ev(32'h1, 0, 0, 16'h7001);
        wr(3'd2, 32'hFFFF_FFFF, 4'hC);
        wr(3'd2, 32'hFFFF_FFFF, 4'hF);
        wr(3'd5, 32'hF, 4'h1);

        cur_req = "R5";
        wr(3'd4, 32'h0, 4'hF);
        ev(32'h8, 0, 0, 16'h5001);
        chk(f_dev_sts == 4'b0100, "fixed-table dev_sts rx overflow", 32'(f_dev_sts), 32'h4);
        wr(3'd5, 32'hF, 4'h1);
        ev(32'h40, 0, 0, 16'h5002);
        chk(f_dev_sts == 4'b0010, "fixed-table dev_sts poisoned", 32'(f_dev_sts), 32'h2);
        cyc();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule